// File: doc/BRIEF.md
# Parallel RGB Panel Scan Timing Generator

This block drives a parallel RGB display panel in the pixel clock domain. It produces horizontal sync, vertical sync, data-enable and the pixel data bus. A line is a sync pulse, then a back porch, then the visible pixels, then a front porch. A frame has the same four parts, counted in lines. All eight timing values, the sync polarities, the bus mode and the pixel depth are run-time configuration inputs. They are held stable outside reset.

Pixels arrive on a ready/valid stream. In wide mode the 16 data lines carry one pixel per clock. In narrow mode only the low 8 data lines are used. A pixel of 16 or 24 bits is then sent as two or three byte beats, most significant byte first. If the stream has no pixel ready when one is due, the panel timing does not stop. The block sends filler zeros, marks a sticky underflow flag, and stops taking pixels until the next frame starts. It then resumes cleanly on the first pixel of the new frame, so a missed pixel never shifts later frames. A software restart request holds the stream off in the same way until the next vertical sync.

Top module: `lcd_scan_gen`

## Requirements
- R1: While rstN is low: hsyncOut and vsyncOut are 1; deOut, dataOut, vsyncEvent, underflowFlag and pixReady are 0.
- R2: The line length is hPulse+hBack+A+hFront clocks, where A = cfgHRes × beats. hsync is active for the first cfgHPulse clocks of each line. On visible lines, deOut is high for exactly A clocks, starting cfgHPulse+cfgHBack clocks after the start of the line. The timing is unchanged by underflow.
- R3: The frame length is cfgVPulse+cfgVBack+cfgVRes+cfgVFront lines. vsync is active for the first cfgVPulse lines. deOut is high only on the cfgVRes lines that follow the sync and back-porch lines. All pulse widths and front porches are at least 1.
- R4: Sync polarity is set per signal. With cfgHsActHigh or cfgVsActHigh at 0, the sync is active-low; at 1 it is active-high.
- R5: Beats per pixel depend on the bus mode and pixel depth.
  - With cfgWideBus=1 there is 1 beat, and dataOut carries pixel bits [15:0].
  - With cfgWideBus=0 and cfgBpp=16 there are 2 beats; with cfgBpp=24 there are 3 beats.
  - In narrow mode the beats carry the pixel bytes most significant first on dataOut[7:0], with dataOut[15:8]=0.
- R6: cfgBpp=0 selects the bus width as the pixel depth: 16 bits in wide mode and 8 bits in narrow mode (1 beat, byte [7:0]). In wide mode any cfgBpp is treated as 16.
- R7: pixReady is high only in the first clock of each visible pixel. A pixel is taken when pixReady and pixValid are both high, and its first beat appears on dataOut with deOut in the next clock.
- R8: dataOut is zero in every clock where deOut is low.
- R9: When pixReady is high and pixValid is low, that pixel is sent as zeros with deOut still high. pixReady then stays low for the rest of the frame.
- R10: After an underflow, the stream resumes at the next frame start: the next frame takes all cfgHRes × cfgVRes pixels.
- R11: A one-clock restartReq stops pixel intake from the next clock until the next frame start, after which the next frame takes every pixel. restartReq does not set underflowFlag.
- R12: underflowFlag rises the clock after an underflow and stays high until an underflowClr pulse clears it. A new underflow takes priority over the clear.
- R13: vsyncEvent is a one-clock pulse on the first clock of each vsync-active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgHPulse | input | H_W | Hsync pulse width, clocks |
| cfgHBack | input | H_W | Horizontal back porch, clocks |
| cfgHRes | input | H_W | Visible pixels per line |
| cfgHFront | input | H_W | Horizontal front porch, clocks |
| cfgVPulse | input | V_W | Vsync pulse width, lines |
| cfgVBack | input | V_W | Vertical back porch, lines |
| cfgVRes | input | V_W | Visible lines per frame |
| cfgVFront | input | V_W | Vertical front porch, lines |
| cfgWideBus | input | 1 | 1: 16-line bus, 0: 8-line bus |
| cfgBpp | input | 5 | Bits per pixel: 0, 8, 16 or 24 |
| cfgHsActHigh | input | 1 | Hsync polarity, 1 = active-high |
| cfgVsActHigh | input | 1 | Vsync polarity, 1 = active-high |
| pixIn | input | 24 | Pixel word |
| pixValid | input | 1 | Pixel word valid |
| pixReady | output | 1 | Block takes a pixel this clock |
| restartReq | input | 1 | Hold off stream until next frame start |
| underflowClr | input | 1 | Clear the sticky underflow flag |
| hsyncOut | output | 1 | Horizontal sync |
| vsyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| dataOut | output | 16 | Panel data bus |
| vsyncEvent | output | 1 | Pulse at start of vertical sync |
| underflowFlag | output | 1 | Sticky underflow indicator |

## Verification
Some properties hold every cycle, and the embedded assertions check these:
- data-enable never overlaps the horizontal sync;
- data is zero whenever data-enable is low;
- the vsync event is a single clock and coincides with vsync being active;
- an underflow raises the flag in the following clock, and the flag holds until cleared;
- a restart request drops ready in the next clock.

Other behaviours can only be shown by the bench scenarios:
- the exact porch and pulse lengths for several configurations;
- the byte order and beat count of serialized pixels;
- that no pixel is taken for the rest of a starved or restarted frame;
- that a full frame of pixels is taken after the next vertical sync.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
  localparam int PIX_W  = 24;
  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;

  // strobes from scan control to datapath
  typedef struct packed {
    logic       active;     // visible clock
    logic       loadPix;    // first beat of a pixel
    logic [1:0] beat;       // beat index inside pixel
    logic       frameStart; // first clock of frame
  } scanStrobe_t;

  function automatic logic [1:0] beatsOf(input logic wide, input logic [4:0] bpp);
    if (wide) return 2'd1;
    case (bpp)
      5'd16:   return 2'd2;
      5'd24:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/lcd_scan_ctrl.sv
`timescale 1ns/1ps
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [H_W-1:0] cfgHPulse,
  input  logic [H_W-1:0] cfgHBack,
  input  logic [H_W-1:0] cfgHRes,
  input  logic [H_W-1:0] cfgHFront,
  input  logic [V_W-1:0] cfgVPulse,
  input  logic [V_W-1:0] cfgVBack,
  input  logic [V_W-1:0] cfgVRes,
  input  logic [V_W-1:0] cfgVFront,
  input  logic           cfgWideBus,
  input  logic [4:0]     cfgBpp,
  input  logic           cfgHsActHigh,
  input  logic           cfgVsActHigh,
  output scanStrobe_t    strobe,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           deOut,
  output logic           vsyncEvent
);
  localparam int HS_W = H_W + 3;
  localparam int VS_W = V_W + 2;

  logic [1:0]      beats;
  logic [HS_W-1:0] actLen, hActStart, hActEnd, hTotal, hCount;
  logic [VS_W-1:0] vActStart, vActEnd, vTotal, vCount;
  logic [1:0]      beat;
  logic            lineEnd, frameEnd, hIn, vIn, act, hsAct, vsAct;

  assign beats = beatsOf(cfgWideBus, cfgBpp);

  always_comb begin
    case (beats)
      2'd2:    actLen = HS_W'(cfgHRes) << 1;
      2'd3:    actLen = (HS_W'(cfgHRes) << 1) + HS_W'(cfgHRes);
      default: actLen = HS_W'(cfgHRes);
    endcase
    hActStart = HS_W'(cfgHPulse) + HS_W'(cfgHBack);
    hActEnd   = hActStart + actLen;
    hTotal    = hActEnd + HS_W'(cfgHFront);
    vActStart = VS_W'(cfgVPulse) + VS_W'(cfgVBack);
    vActEnd   = vActStart + VS_W'(cfgVRes);
    vTotal    = vActEnd + VS_W'(cfgVFront);
  end

  assign lineEnd  = (hCount == hTotal - HS_W'(1));
  assign frameEnd = (vCount == vTotal - VS_W'(1));
  assign hIn      = (hCount >= hActStart) && (hCount < hActEnd);
  assign vIn      = (vCount >= vActStart) && (vCount < vActEnd);
  assign act      = hIn && vIn;
  assign hsAct    = hCount < HS_W'(cfgHPulse);
  assign vsAct    = vCount < VS_W'(cfgVPulse);

  always_comb begin
    strobe.active     = act;
    strobe.beat       = beat;
    strobe.loadPix    = act && (beat == 2'd0);
    strobe.frameStart = (hCount == '0) && (vCount == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount     <= '0;
      vCount     <= '0;
      beat       <= '0;
      hsyncOut   <= 1'b1;
      vsyncOut   <= 1'b1;
      deOut      <= 1'b0;
      vsyncEvent <= 1'b0;
    end else begin
      if (lineEnd) begin
        hCount <= '0;
        vCount <= frameEnd ? '0 : vCount + VS_W'(1);
      end else begin
        hCount <= hCount + HS_W'(1);
      end
      if (act) beat <= (beat == beats - 2'd1) ? 2'd0 : beat + 2'd1;
      else     beat <= 2'd0;
      hsyncOut   <= cfgHsActHigh ? hsAct : !hsAct;
      vsyncOut   <= cfgVsActHigh ? vsAct : !vsAct;
      deOut      <= act;
      vsyncEvent <= strobe.frameStart;
    end
  end

  // R2
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> (hsyncOut != cfgHsActHigh));
  // R13
  event_in_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    vsyncEvent |-> (vsyncOut == cfgVsActHigh));
  // R13
  event_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    vsyncEvent |=> !vsyncEvent);
endmodule

// File: rtl/lcd_scan_dp.sv
`timescale 1ns/1ps
module lcd_scan_dp
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strobe,
  input  logic             cfgWideBus,
  input  logic [4:0]       cfgBpp,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic             restartReq,
  input  logic             underflowClr,
  output logic [BUS_W-1:0] dataOut,
  output logic             underflowFlag
);
  logic [1:0]       beats;
  logic             muted, take, starve;
  logic [PIX_W-1:0] holdWord;

  assign beats    = beatsOf(cfgWideBus, cfgBpp);
  assign pixReady = strobe.loadPix && !muted;
  assign take     = pixReady && pixValid;
  assign starve   = pixReady && !pixValid;

  // lane select: wide bus passes low half, narrow bus sends MSB byte first
  function automatic logic [BUS_W-1:0] laneOf(input logic [PIX_W-1:0] word,
                                               input logic wide,
                                               input logic [1:0] nBeats,
                                               input logic [1:0] idx);
    logic [1:0]       byteSel;
    logic [PIX_W-1:0] shifted;
    if (wide) return word[BUS_W-1:0];
    byteSel = nBeats - 2'd1 - idx;
    shifted = word >> (LANE_W * byteSel);
    return {{(BUS_W-LANE_W){1'b0}}, shifted[LANE_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord      <= '0;
      dataOut       <= '0;
      muted         <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (!strobe.active) begin
        dataOut <= '0;
      end else if (strobe.loadPix) begin
        if (take) begin
          holdWord <= pixIn;
          dataOut  <= laneOf(pixIn, cfgWideBus, beats, 2'd0);
        end else begin
          holdWord <= '0;
          dataOut  <= '0;
        end
      end else begin
        dataOut <= laneOf(holdWord, cfgWideBus, beats, strobe.beat);
      end

      if (restartReq || starve)  muted <= 1'b1;
      else if (strobe.frameStart) muted <= 1'b0;

      if (starve)            underflowFlag <= 1'b1;
      else if (underflowClr) underflowFlag <= 1'b0;
    end
  end

  // R12
  starve_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixReady && !pixValid) |=> underflowFlag);
  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowFlag && !underflowClr) |=> underflowFlag);
  // R11
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !pixReady);
endmodule

// File: rtl/lcd_scan_gen.sv
`timescale 1ns/1ps
module lcd_scan_gen
  import lcd_scan_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [H_W-1:0]   cfgHPulse,
  input  logic [H_W-1:0]   cfgHBack,
  input  logic [H_W-1:0]   cfgHRes,
  input  logic [H_W-1:0]   cfgHFront,
  input  logic [V_W-1:0]   cfgVPulse,
  input  logic [V_W-1:0]   cfgVBack,
  input  logic [V_W-1:0]   cfgVRes,
  input  logic [V_W-1:0]   cfgVFront,
  input  logic             cfgWideBus,
  input  logic [4:0]       cfgBpp,
  input  logic             cfgHsActHigh,
  input  logic             cfgVsActHigh,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixValid,
  output logic             pixReady,
  input  logic             restartReq,
  input  logic             underflowClr,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic [BUS_W-1:0] dataOut,
  output logic             vsyncEvent,
  output logic             underflowFlag
);
  scanStrobe_t strobe;

  lcd_scan_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgHPulse(cfgHPulse), .cfgHBack(cfgHBack), .cfgHRes(cfgHRes), .cfgHFront(cfgHFront),
    .cfgVPulse(cfgVPulse), .cfgVBack(cfgVBack), .cfgVRes(cfgVRes), .cfgVFront(cfgVFront),
    .cfgWideBus(cfgWideBus), .cfgBpp(cfgBpp),
    .cfgHsActHigh(cfgHsActHigh), .cfgVsActHigh(cfgVsActHigh),
    .strobe(strobe), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .vsyncEvent(vsyncEvent)
  );

  lcd_scan_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgWideBus(cfgWideBus), .cfgBpp(cfgBpp),
    .pixIn(pixIn), .pixValid(pixValid), .pixReady(pixReady),
    .restartReq(restartReq), .underflowClr(underflowClr),
    .dataOut(dataOut), .underflowFlag(underflowFlag)
  );

  // R8
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut != '0) |-> deOut);
endmodule

// File: tb/lcd_scan_gen_bench.sv
`timescale 1ns/1ps
module lcd_scan_gen_bench;
  localparam int H_W = 12;
  localparam int V_W = 12;
  localparam int LIMIT = 5000;

  typedef struct packed {
    logic [7:0] hP, hB, hR, hF, vP, vB, vR, vF;
    logic       wide;
    logic [4:0] bpp;
    logic       hsHi, vsHi;
    logic [1:0] beats;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd1, 8'd3, 8'd5, 8'd2, 8'd1, 8'd2, 8'd3, 8'd1, 1'b1, 5'd0,  1'b0, 1'b0, 2'd1},
    '{8'd2, 8'd2, 8'd4, 8'd3, 8'd2, 8'd1, 8'd2, 8'd2, 1'b0, 5'd24, 1'b1, 1'b0, 2'd3},
    '{8'd1, 8'd1, 8'd3, 8'd1, 8'd1, 8'd1, 8'd4, 8'd1, 1'b0, 5'd16, 1'b0, 1'b1, 2'd2},
    '{8'd3, 8'd2, 8'd6, 8'd2, 8'd1, 8'd3, 8'd2, 8'd2, 1'b0, 5'd0,  1'b1, 1'b1, 2'd1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [H_W-1:0] cfgHPulse, cfgHBack, cfgHRes, cfgHFront;
  logic [V_W-1:0] cfgVPulse, cfgVBack, cfgVRes, cfgVFront;
  logic cfgWideBus, cfgHsActHigh, cfgVsActHigh;
  logic [4:0] cfgBpp;
  logic [23:0] pixIn;
  logic pixValid = 1'b1, pixReady, restartReq = 1'b0, underflowClr = 1'b0;
  logic hsyncOut, vsyncOut, deOut, vsyncEvent, underflowFlag;
  logic [15:0] dataOut;
  int checks = 0, failures = 0, srcIdx = 0;

  always #2 clk = ~clk;

  lcd_scan_gen #(.H_W(H_W), .V_W(V_W)) u_lcd_scan_gen (
    .clk(clk), .rstN(rstN),
    .cfgHPulse(cfgHPulse), .cfgHBack(cfgHBack), .cfgHRes(cfgHRes), .cfgHFront(cfgHFront),
    .cfgVPulse(cfgVPulse), .cfgVBack(cfgVBack), .cfgVRes(cfgVRes), .cfgVFront(cfgVFront),
    .cfgWideBus(cfgWideBus), .cfgBpp(cfgBpp),
    .cfgHsActHigh(cfgHsActHigh), .cfgVsActHigh(cfgVsActHigh),
    .pixIn(pixIn), .pixValid(pixValid), .pixReady(pixReady),
    .restartReq(restartReq), .underflowClr(underflowClr),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .dataOut(dataOut),
    .vsyncEvent(vsyncEvent), .underflowFlag(underflowFlag)
  );

  function automatic logic [23:0] pixOf(input int i);
    logic [5:0] t = i[5:0];
    return {2'b11, t, 2'b10, t, 2'b01, t};
  endfunction

  function automatic logic [15:0] laneExp(input logic [23:0] w, input bit wide,
                                          input int nb, input int k);
    logic [23:0] s;
    if (wide) return w[15:0];
    s = w >> (8 * (nb - 1 - k));
    return {8'h00, s[7:0]};
  endfunction

  assign pixIn = pixOf(srcIdx);
  always @(posedge clk) if (pixReady && pixValid) srcIdx <= srcIdx + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    rstN = 1'b0;
    cfgHPulse = H_W'(v.hP); cfgHBack = H_W'(v.hB); cfgHRes = H_W'(v.hR); cfgHFront = H_W'(v.hF);
    cfgVPulse = V_W'(v.vP); cfgVBack = V_W'(v.vB); cfgVRes = V_W'(v.vR); cfgVFront = V_W'(v.vF);
    cfgWideBus = v.wide; cfgBpp = v.bpp; cfgHsActHigh = v.hsHi; cfgVsActHigh = v.vsHi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitEvent();
    int n = 0;
    @(negedge clk);
    while (!vsyncEvent && n < LIMIT) begin @(negedge clk); n++; end
    if (n >= LIMIT) check(1'b0, "wait vsyncEvent", n, 0);
  endtask

  task automatic waitReady();
    int n = 0;
    while (!pixReady && n < LIMIT) begin @(negedge clk); n++; end
    if (n >= LIMIT) check(1'b0, "wait pixReady", n, 0);
  endtask

  // counts readies and handshakes from now up to the next vsyncEvent
  task automatic countToEvent(output int rdy, output int hsk, output int len);
    rdy = 0; hsk = 0; len = 0;
    do begin
      if (pixReady) rdy++;
      if (pixReady && pixValid) hsk++;
      len++;
      @(negedge clk);
    end while (!vsyncEvent && len < LIMIT);
  endtask

  task automatic measure(input vec_t v);
    int hTot, vTot, len, deCnt, hsCnt, vsCnt, firstDe, hsk, dataBad, idleBad, base, nb;
    bit prevVs, polOk;
    nb = int'(v.beats);
    hTot = v.hP + v.hB + v.hR * nb + v.hF;
    vTot = v.vP + v.vB + v.vR + v.vF;
    waitEvent();
    polOk = (hsyncOut == v.hsHi) && (vsyncOut == v.vsHi);
    base = srcIdx;
    len = 0; deCnt = 0; hsCnt = 0; vsCnt = 0; firstDe = -1; hsk = 0;
    dataBad = 0; idleBad = 0; prevVs = vsyncOut;
    do begin
      if (deOut) begin
        if (dataOut != laneExp(pixOf(base + deCnt / nb), v.wide, nb, deCnt % nb)) dataBad++;
        if (firstDe < 0) firstDe = len;
        deCnt++;
      end else if (dataOut != 16'h0) idleBad++;
      if (hsyncOut == v.hsHi) hsCnt++;
      if (vsyncOut == v.vsHi) vsCnt++;
      if (pixReady && pixValid) hsk++;
      prevVs = vsyncOut;
      len++;
      @(negedge clk);
    end while (!vsyncEvent && len < LIMIT);
    check(polOk, "R4 sync polarity at frame start", int'(polOk), 1);
    check(len == hTot * vTot, "R3 frame length", len, hTot * vTot);
    check(vsCnt == v.vP * hTot, "R3 vsync active clocks", vsCnt, v.vP * hTot);
    check(hsCnt == v.hP * vTot, "R2 hsync active clocks", hsCnt, v.hP * vTot);
    check(deCnt == v.hR * nb * v.vR, "R2 R5 de clocks per frame", deCnt, v.hR * nb * v.vR);
    check(firstDe == (v.vP + v.vB) * hTot + v.hP + v.hB, "R2 R3 first de offset",
          firstDe, (v.vP + v.vB) * hTot + v.hP + v.hB);
    check(hsk == v.hR * v.vR, "R7 pixels taken per frame", hsk, v.hR * v.vR);
    check(dataBad == 0, "R5 R6 R7 beat data order", dataBad, 0);
    check(idleBad == 0, "R8 idle data zero", idleBad, 0);
    check((vsyncOut == v.vsHi) && (prevVs != v.vsHi), "R13 event on vsync onset",
          int'(vsyncOut), int'(v.vsHi));
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rdy, hsk, len;
    applyVec(VECS[0]);
    rstN = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(hsyncOut && vsyncOut && !deOut && dataOut == 16'h0 && !vsyncEvent &&
          !underflowFlag && !pixReady, "R1 reset state",
          {hsyncOut, vsyncOut, deOut, vsyncEvent, underflowFlag, pixReady}, 6'b110000);

    for (int i = 0; i < 4; i++) begin
      applyVec(VECS[i]);
      measure(VECS[i]);
    end

    // R9 R10 R12 underflow: config 0 (hTot 11, vTot 7, 15 pixels)
    applyVec(VECS[0]);
    waitEvent();
    waitReady();
    pixValid = 1'b0;
    @(negedge clk);
    pixValid = 1'b1;
    check(deOut && dataOut == 16'h0, "R9 filler on underflow", int'(dataOut), 0);
    check(underflowFlag, "R12 flag set after underflow", int'(underflowFlag), 1);
    countToEvent(rdy, hsk, len);
    check(rdy == 0, "R9 no ready for rest of frame", rdy, 0);
    countToEvent(rdy, hsk, len);
    check(hsk == 15, "R10 full frame after resync", hsk, 15);
    check(len == 77, "R2 timing unchanged after underflow", len, 77);
    check(underflowFlag, "R12 flag sticky", int'(underflowFlag), 1);
    underflowClr = 1'b1;
    @(negedge clk);
    underflowClr = 1'b0;
    check(!underflowFlag, "R12 flag cleared", int'(underflowFlag), 0);

    // R11 restart request
    waitEvent();
    waitReady();
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    countToEvent(rdy, hsk, len);
    check(rdy == 0, "R11 intake held after restart", rdy, 0);
    check(!underflowFlag, "R11 restart leaves flag low", int'(underflowFlag), 0);
    countToEvent(rdy, hsk, len);
    check(hsk == 15, "R11 full frame after restart", hsk, 15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule